// File: doc/BRIEF.md
# Write-Back Cache Controller

This block controls a small direct-mapped, write-back data cache of 256 bytes, arranged as 8 lines of 32 one-byte words. It sits between a synchronous processor port, an external single-port block RAM that holds the cached bytes, and a main-memory controller that moves one byte per strobe. The tag, valid and dirty state of every line lives in registers inside the block. The data bytes live in the external RAM.

Each processor request is classified as a read hit, a write hit, a miss to a clean line, or a miss to a dirty line. For a clean miss, the controller fetches the whole line from main memory. For a dirty miss, it first writes the victim line back at its stored tag and then fetches the new line. In both miss cases, it then finishes the original access in the same way as a hit. While a request is in progress, a ready output stays low.

Top module: `wb_cache_ctrl`

## Requirements
- R1: The 16-bit request address splits into tag = bits [15:8], line index = bits [7:5] and byte offset = bits [4:0]. A hit accesses the local RAM at the 8-bit address {index, offset}.
- R2: After reset, every line is invalid and clean, ready is high, and neither the memory strobe nor the RAM write enable is asserted.
- R3: A request is captured in the first cycle in which the select input is high while ready is high. Select-high cycles that follow in the same request are ignored. A new request needs select to have been seen low first.
- R4: Ready drops in the cycle after a request is captured and stays low until the access is complete. A write hit keeps ready low for exactly 1 cycle. A read hit keeps it low for exactly 2 cycles.
- R5: A write hit stores the byte in local RAM and marks the line dirty.
- R6: A read returns the addressed byte on the read-data output by the time ready rises. That output stays unchanged while ready is high and across write requests.
- R7: A miss fills the line with 32 main-memory reads at addresses {new tag, index, 0..31}, in ascending order.
- R8: A miss to a dirty line first performs 32 main-memory writes of the stored bytes to {old tag, index, 0..31}, in ascending order, and only then starts the fill.
- R9: For every main-memory transfer, the address, direction (1 = write) and write data are already present in the cycle before the strobe. The strobe is high for a single cycle.
- R10: Fill data is taken from the memory read-data input exactly MEM_LAT cycles after that byte's strobe.
- R11: A filled line is clean, so replacing it later with no write in between causes no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuSel | input | 1 | Request select, held high for 4 cycles per request |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 16 | Request address |
| cpuWdata | input | 8 | Write data from the processor |
| cpuRdata | output | 8 | Read data to the processor |
| cpuReady | output | 1 | High when idle and able to accept a request |
| ramAddr | output | 8 | Local RAM address |
| ramWdata | output | 8 | Local RAM write data |
| ramWen | output | 1 | Local RAM write enable |
| ramRdata | input | 8 | Local RAM read data, valid one edge after the address |
| memAddr | output | 16 | Main-memory byte address |
| memWrite | output | 1 | Main-memory direction, 1 = write |
| memWdata | output | 8 | Main-memory write data |
| memStrobe | output | 1 | One-cycle transfer strobe |
| memRdata | input | 8 | Main-memory read data |

## Verification
The bench builds the controller with MEM_LAT = 3 rather than the default of 1. This exercises the latency wait counter over several cycles. Between strobes, the modelled memory drives a junk byte, so sampling even one cycle early or late corrupts the line. The remaining parameters keep their defaults, so the bench can hold the full 256-byte store and the 8 tags in a plain behavioural model. A randomised phase chooses among four tags on all 8 lines, which produces chains of hits, clean misses and dirty misses on the same index.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_LOOKUP,
    S_RDCAP,
    S_WB_RD,
    S_WB_LD,
    S_WB_SETUP,
    S_WB_STB,
    S_FL_SET,
    S_FL_SETUP,
    S_FL_STB,
    S_FL_WAIT
  } ctrlState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic awrLoad;    // capture request
    logic cntClr;     // clear byte counter
    logic cntInc;     // advance byte counter
    logic useCnt;     // RAM address/data from line transfer
    logic ramWen;     // local RAM write
    logic memLoad;    // load memory bus registers
    logic memWr;      // direction loaded with memLoad
    logic useOldTag;  // memory address uses stored tag
    logic lineFill;   // install new tag, valid, clean
    logic lineDirty;  // mark line dirty
    logic rdCapture;  // latch RAM output for CPU
  } ctlStrobe_t;

endpackage

// File: rtl/wbc_datapath.sv
module wbc_datapath
  import wbc_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobe_t                    ctl,
  input  logic                          cpuWrite,
  input  logic [TAG_W+IDX_W+OFF_W-1:0]  cpuAddr,
  input  logic [DATA_W-1:0]             cpuWdata,
  output logic [DATA_W-1:0]             cpuRdata,
  output logic [IDX_W+OFF_W-1:0]        ramAddr,
  output logic [DATA_W-1:0]             ramWdata,
  output logic                          ramWen,
  input  logic [DATA_W-1:0]             ramRdata,
  output logic [TAG_W+IDX_W+OFF_W-1:0]  memAddr,
  output logic                          memWrite,
  output logic [DATA_W-1:0]             memWdata,
  input  logic [DATA_W-1:0]             memRdata,
  output logic                          hit,
  output logic                          victimDirty,
  output logic                          reqWrite,
  output logic                          cntLast
);

  localparam int ADDR_W = TAG_W + IDX_W + OFF_W;
  localparam int LINES  = 1 << IDX_W;

  // address word register
  logic [TAG_W-1:0]  awrTag;
  logic [IDX_W-1:0]  awrIdx;
  logic [OFF_W-1:0]  awrOff;
  logic              awrWrite;
  logic [DATA_W-1:0] awrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      awrTag   <= '0;
      awrIdx   <= '0;
      awrOff   <= '0;
      awrWrite <= 1'b0;
      awrData  <= '0;
    end else if (ctl.awrLoad) begin
      awrTag   <= cpuAddr[ADDR_W-1 -: TAG_W];
      awrIdx   <= cpuAddr[OFF_W +: IDX_W];
      awrOff   <= cpuAddr[OFF_W-1:0];
      awrWrite <= cpuWrite;
      awrData  <= cpuWdata;
    end
  end

  // line state
  logic [TAG_W-1:0] tagArr [LINES];
  logic [LINES-1:0] validArr;
  logic [LINES-1:0] dirtyArr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validArr <= '0;
      dirtyArr <= '0;
    end else begin
      if (ctl.lineFill) begin
        validArr[awrIdx] <= 1'b1;
        dirtyArr[awrIdx] <= 1'b0;
      end
      if (ctl.lineDirty) begin
        dirtyArr[awrIdx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.lineFill) begin
      tagArr[awrIdx] <= awrTag;
    end
  end

  // per-line tag compare
  logic [LINES-1:0] lineHit;
  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign lineHit[g] = validArr[g] && (tagArr[g] == awrTag);
  end

  assign hit         = lineHit[awrIdx];
  assign victimDirty = validArr[awrIdx] && dirtyArr[awrIdx];
  assign reqWrite    = awrWrite;

  // line transfer byte counter
  logic [OFF_W-1:0] cnt;
  always_ff @(posedge clk) begin
    if (!rstN || ctl.cntClr) begin
      cnt <= '0;
    end else if (ctl.cntInc) begin
      cnt <= cnt + 1'b1;
    end
  end
  assign cntLast = &cnt;

  // local RAM side
  assign ramAddr  = {awrIdx, ctl.useCnt ? cnt : awrOff};
  assign ramWdata = ctl.useCnt ? memRdata : awrData;
  assign ramWen   = ctl.ramWen;

  // main memory bus registers
  logic [TAG_W-1:0] busTag;
  assign busTag = ctl.useOldTag ? tagArr[awrIdx] : awrTag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr  <= '0;
      memWrite <= 1'b0;
      memWdata <= '0;
    end else if (ctl.memLoad) begin
      memAddr  <= {busTag, awrIdx, cnt};
      memWrite <= ctl.memWr;
      memWdata <= ramRdata;
    end
  end

  // CPU read data
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuRdata <= '0;
    end else if (ctl.rdCapture) begin
      cpuRdata <= ramRdata;
    end
  end

  // R7: installing a line makes the pending request hit
  p_fill_then_hit_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lineFill |=> hit);

  // R5: a write hit leaves the line dirty
  p_write_marks_dirty_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lineDirty |=> victimDirty);

endmodule

// File: rtl/wbc_control.sv
module wbc_control
  import wbc_pkg::*;
#(
  parameter int MEM_LAT = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuSel,
  input  logic       hit,
  input  logic       victimDirty,
  input  logic       reqWrite,
  input  logic       cntLast,
  output ctlStrobe_t ctl,
  output logic       cpuReady,
  output logic       memStrobe
);

  localparam int LAT_W = $clog2(MEM_LAT + 1);

  ctrlState_t       state, nxt;
  logic             armed;
  logic [LAT_W-1:0] latCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else begin
      state <= nxt;
    end
  end

  // a new request needs select to be seen low first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b1;
    end else if (!cpuSel) begin
      armed <= 1'b1;
    end else if (state == S_IDLE) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latCnt <= '0;
    end else if (state == S_FL_STB) begin
      latCnt <= LAT_W'(1);
    end else if (state == S_FL_WAIT) begin
      latCnt <= latCnt + 1'b1;
    end
  end

  always_comb begin
    ctl       = '0;
    nxt       = state;
    memStrobe = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (cpuSel && armed) begin
          ctl.awrLoad = 1'b1;
          nxt         = S_LOOKUP;
        end
      end
      S_LOOKUP: begin
        ctl.cntClr = 1'b1;
        if (hit) begin
          if (reqWrite) begin
            ctl.ramWen    = 1'b1;
            ctl.lineDirty = 1'b1;
            nxt           = S_IDLE;
          end else begin
            nxt = S_RDCAP;
          end
        end else if (victimDirty) begin
          nxt = S_WB_RD;
        end else begin
          nxt = S_FL_SET;
        end
      end
      S_RDCAP: begin
        ctl.rdCapture = 1'b1;
        nxt           = S_IDLE;
      end
      S_WB_RD: begin
        ctl.useCnt = 1'b1;
        nxt        = S_WB_LD;
      end
      S_WB_LD: begin
        ctl.useCnt    = 1'b1;
        ctl.memLoad   = 1'b1;
        ctl.memWr     = 1'b1;
        ctl.useOldTag = 1'b1;
        nxt           = S_WB_SETUP;
      end
      S_WB_SETUP: nxt = S_WB_STB;
      S_WB_STB: begin
        memStrobe  = 1'b1;
        ctl.cntInc = 1'b1;
        nxt        = cntLast ? S_FL_SET : S_WB_RD;
      end
      S_FL_SET: begin
        ctl.memLoad = 1'b1;
        nxt         = S_FL_SETUP;
      end
      S_FL_SETUP: nxt = S_FL_STB;
      S_FL_STB: begin
        memStrobe = 1'b1;
        nxt       = S_FL_WAIT;
      end
      S_FL_WAIT: begin
        if (latCnt == LAT_W'(MEM_LAT)) begin
          ctl.useCnt = 1'b1;
          ctl.ramWen = 1'b1;
          ctl.cntInc = 1'b1;
          if (cntLast) begin
            ctl.lineFill = 1'b1;
            nxt          = S_LOOKUP;
          end else begin
            nxt = S_FL_SET;
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign cpuReady = (state == S_IDLE);

  // R9: strobe lasts a single cycle
  p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    memStrobe |=> !memStrobe);

  // R4: capturing a request drops ready next cycle
  p_accept_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady && cpuSel && armed) |=> !cpuReady);

  // R4: no memory traffic while reporting ready
  p_busy_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    memStrobe |-> !cpuReady);

endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
  import wbc_pkg::*;
#(
  parameter int TAG_W   = 8,
  parameter int IDX_W   = 3,
  parameter int OFF_W   = 5,
  parameter int DATA_W  = 8,
  parameter int MEM_LAT = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cpuSel,
  input  logic                          cpuWrite,
  input  logic [TAG_W+IDX_W+OFF_W-1:0]  cpuAddr,
  input  logic [DATA_W-1:0]             cpuWdata,
  output logic [DATA_W-1:0]             cpuRdata,
  output logic                          cpuReady,
  output logic [IDX_W+OFF_W-1:0]        ramAddr,
  output logic [DATA_W-1:0]             ramWdata,
  output logic                          ramWen,
  input  logic [DATA_W-1:0]             ramRdata,
  output logic [TAG_W+IDX_W+OFF_W-1:0]  memAddr,
  output logic                          memWrite,
  output logic [DATA_W-1:0]             memWdata,
  output logic                          memStrobe,
  input  logic [DATA_W-1:0]             memRdata
);

  ctlStrobe_t ctl;
  logic       hit;
  logic       victimDirty;
  logic       reqWrite;
  logic       cntLast;

  wbc_control #(
    .MEM_LAT (MEM_LAT)
  ) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .cpuSel      (cpuSel),
    .hit         (hit),
    .victimDirty (victimDirty),
    .reqWrite    (reqWrite),
    .cntLast     (cntLast),
    .ctl         (ctl),
    .cpuReady    (cpuReady),
    .memStrobe   (memStrobe)
  );

  wbc_datapath #(
    .TAG_W  (TAG_W),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .cpuWrite    (cpuWrite),
    .cpuAddr     (cpuAddr),
    .cpuWdata    (cpuWdata),
    .cpuRdata    (cpuRdata),
    .ramAddr     (ramAddr),
    .ramWdata    (ramWdata),
    .ramWen      (ramWen),
    .ramRdata    (ramRdata),
    .memAddr     (memAddr),
    .memWrite    (memWrite),
    .memWdata    (memWdata),
    .memRdata    (memRdata),
    .hit         (hit),
    .victimDirty (victimDirty),
    .reqWrite    (reqWrite),
    .cntLast     (cntLast)
  );

  // R9: bus fields settle one cycle ahead of the strobe
  p_mem_setup_r9: assert property (@(posedge clk) disable iff (!rstN)
    memStrobe |-> ($stable(memAddr) && $stable(memWrite) && $stable(memWdata)));

  // R6: read data holds while idle
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady && $past(cpuReady)) |-> $stable(cpuRdata));

endmodule

// File: tb/wb_cache_ctrl_bench.sv
module wb_cache_ctrl_bench;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cpuSel;
  logic        cpuWrite;
  logic [15:0] cpuAddr;
  logic [7:0]  cpuWdata;
  logic [7:0]  cpuRdata;
  logic        cpuReady;
  logic [7:0]  ramAddr;
  logic [7:0]  ramWdata;
  logic        ramWen;
  logic [7:0]  ramRdata;
  logic [15:0] memAddr;
  logic        memWrite;
  logic [7:0]  memWdata;
  logic        memStrobe;
  logic [7:0]  memRdata;

  always #10 clk = ~clk;

  wb_cache_ctrl #(.MEM_LAT(LAT)) u_wb_cache_ctrl (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cpuReady(cpuReady), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .ramWen(ramWen), .ramRdata(ramRdata), .memAddr(memAddr),
    .memWrite(memWrite), .memWdata(memWdata), .memStrobe(memStrobe),
    .memRdata(memRdata)
  );

  int checks = 0;
  int errors = 0;
  int lowCnt = 0;

  task automatic checkEq(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  // local RAM: synchronous, read-before-write
  logic [7:0] ramArr [256];
  initial for (int i = 0; i < 256; i++) ramArr[i] = 8'h00;
  always @(posedge clk) begin
    if (ramWen) ramArr[ramAddr] <= ramWdata;
    ramRdata <= ramArr[ramAddr];
  end

  // main memory with fixed read latency, junk between strobes
  logic [7:0] mainMem [int];
  function automatic logic [7:0] mainRd(int a);
    if (mainMem.exists(a)) return mainMem[a];
    return 8'(a ^ (a >> 8) ^ 8'h5A);
  endfunction

  int         pendCnt = 0;
  logic [7:0] pendData;
  initial memRdata = 8'hEE;
  always @(posedge clk) begin
    logic [7:0] nxtData;
    nxtData = 8'hEE;
    if (pendCnt > 0) begin
      pendCnt--;
      if (pendCnt == 0) nxtData = pendData;
    end
    if (memStrobe && memWrite) mainMem[int'(memAddr)] = memWdata;
    if (memStrobe && !memWrite) begin
      if (LAT == 1) nxtData = mainRd(int'(memAddr));
      else begin
        pendData = mainRd(int'(memAddr));
        pendCnt  = LAT - 1;
      end
    end
    memRdata <= nxtData;
  end

  // expected transfer queue
  typedef struct {
    bit          wr;
    logic [15:0] a;
    logic [7:0]  d;
  } op_t;
  op_t expQ[$];

  logic        prevStrobe = 1'b0;
  logic [15:0] prevAddr;
  logic        prevWrite;
  logic [7:0]  prevWdata;

  always @(negedge clk) begin
    if (rstN) begin
      if (!cpuReady) lowCnt++;
      if (memStrobe) begin
        checkEq("R9 strobe follows a low cycle", int'(prevStrobe), 0);
        checkEq("R9 address set before strobe", int'(prevAddr), int'(memAddr));
        checkEq("R9 direction set before strobe", int'(prevWrite), int'(memWrite));
        if (memWrite) checkEq("R9 data set before strobe", int'(prevWdata), int'(memWdata));
        if (expQ.size() == 0) begin
          checkEq("R11/R7 unexpected transfer at address", int'(memAddr), -1);
        end else begin
          op_t op;
          op = expQ.pop_front();
          checkEq(op.wr ? "R8 transfer direction" : "R7 transfer direction",
                  int'(memWrite), int'(op.wr));
          checkEq(op.wr ? "R8 write-back address" : "R7 fill address",
                  int'(memAddr), int'(op.a));
          if (op.wr) checkEq("R8 write-back data", int'(memWdata), int'(op.d));
        end
      end
      prevStrobe = memStrobe;
      prevAddr   = memAddr;
      prevWrite  = memWrite;
      prevWdata  = memWdata;
    end
  end

  // behavioural cache model
  logic [7:0] mTag [8];
  bit         mValid [8];
  bit         mDirty [8];
  logic [7:0] mLine [256];

  task automatic doReq(bit wr, logic [15:0] a, logic [7:0] d);
    int         idx = int'(a[7:5]);
    int         off = int'(a[4:0]);
    logic [7:0] tag = a[15:8];
    bit         hitM;
    logic [7:0] expRead;
    logic [7:0] prevRd;
    hitM = mValid[idx] && (mTag[idx] == tag);
    if (!hitM) begin
      if (mValid[idx] && mDirty[idx]) begin
        for (int i = 0; i < 32; i++)
          expQ.push_back('{1'b1, {mTag[idx], 3'(idx), 5'(i)}, mLine[idx*32+i]});
      end
      for (int i = 0; i < 32; i++) begin
        expQ.push_back('{1'b0, {tag, 3'(idx), 5'(i)}, 8'h00});
        mLine[idx*32+i] = mainRd(int'({tag, 3'(idx), 5'(i)}));
      end
      mTag[idx]   = tag;
      mValid[idx] = 1'b1;
      mDirty[idx] = 1'b0;
    end
    if (wr) begin
      mLine[idx*32+off] = d;
      mDirty[idx]       = 1'b1;
    end
    expRead = mLine[idx*32+off];
    prevRd  = cpuRdata;

    cpuAddr  = a;
    cpuWrite = wr;
    cpuWdata = d;
    @(negedge clk);
    cpuSel = 1'b1;
    lowCnt = 0;
    repeat (4) @(negedge clk);
    if (hitM) checkEq("R3 trailing select ignored, ready", int'(cpuReady), 1);
    cpuSel = 1'b0;
    while (!cpuReady) @(negedge clk);
    if (hitM) checkEq(wr ? "R4 write hit busy cycles" : "R4 read hit busy cycles",
                      lowCnt, wr ? 1 : 2);
    checkEq("R7/R8 transfers outstanding", expQ.size(), 0);
    if (wr) checkEq("R6 read data kept across write", int'(cpuRdata), int'(prevRd));
    else    checkEq("R1/R6/R10 read data", int'(cpuRdata), int'(expRead));
    @(negedge clk);
    if (!wr) checkEq("R6 read data held while ready", int'(cpuRdata), int'(expRead));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R4 watchdog: ready actual %0h expected 1", cpuReady);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 8; i++) begin
      mValid[i] = 1'b0;
      mDirty[i] = 1'b0;
      mTag[i]   = 8'h00;
    end
    rstN     = 1'b0;
    cpuSel   = 1'b0;
    cpuWrite = 1'b0;
    cpuAddr  = '0;
    cpuWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R2 ready after reset", int'(cpuReady), 1);
    checkEq("R2 strobe after reset", int'(memStrobe), 0);
    checkEq("R2 RAM write after reset", int'(ramWen), 0);

    doReq(1'b0, 16'h1234, 8'h00);   // R2 invalid: clean miss
    doReq(1'b0, 16'h1235, 8'h00);   // read hit
    doReq(1'b1, 16'h1236, 8'hA5);   // R5 write hit
    doReq(1'b0, 16'h1236, 8'h00);   // read back
    doReq(1'b0, 16'h5636, 8'h00);   // R8 dirty miss
    doReq(1'b0, 16'h1236, 8'h00);   // R11 clean replace, sees A5
    doReq(1'b1, 16'h00FF, 8'h3C);   // write miss, last offset
    doReq(1'b0, 16'h00FF, 8'h00);
    doReq(1'b0, 16'hFFE0, 8'h00);   // dirty miss on line 7
    doReq(1'b0, 16'h00FF, 8'h00);   // value survived write-back

    lfsr = 16'hACE1;
    for (int n = 0; n < 30; n++) begin
      logic [7:0] tg;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0: tg = 8'h12;
        2'd1: tg = 8'h56;
        2'd2: tg = 8'h9A;
        default: tg = 8'hDE;
      endcase
      doReq(lfsr[10], {tg, lfsr[4:2], lfsr[9:5]}, lfsr[15:8] ^ 8'h3D);
    end

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule